// File: doc/BRIEF.md
# Hard copy handshake controller

This block sits between a storage display and an external hard-copy unit. Three request sources can start a copy: a keyboard key, a software command and the copier's own button. They are merged into a single active-low make-copy request. The copier answers on one of two active-low reply lines. One reply means it is copying this display. The other means it is busy through its multiplexer with a different display. Either reply raises a copy-enable level.

While copy enable is high, the block reports the display as busy and blocks screen erase. It switches the deflection path from the normal X/Y coordinates to the copier's ramp coordinates and selects the hard-copy beam intensity. It also accepts interrogation strobes from the copier. Each accepted strobe becomes a Z-axis pulse of fixed length, which is short enough to read the stored image without writing it.

The reply lines and the interrogation line come from the copier asynchronously, so each is synchronised through two flip-flops. The request triggers and the erase request are synchronous to the block clock.

Top module: `hc_handshake`

## Requirements
- R1: When no copy is pending or running, a high level on any one of kbd_copy_i, cmd_copy_i or btn_copy_i at a clock edge drives make_copy_no low from that edge.
- R2: With no reply, make_copy_no stays low for exactly REQ_TIMEOUT cycles and then returns high, and copy_en_o stays low.
- R3: A low level on read_ni or wait_ni while make_copy_no is low sets copy_en_o high on the third rising edge that samples it, counting the sampling edge as the first. make_copy_no returns high at that same edge.
- R4: copy_en_o stays high while read_ni or wait_ni is low. It falls on the third edge after both lines are high.
- R5: busy_o equals copy_en_o. erase_o follows erase_req_i while copy_en_o is low and is held low while copy_en_o is high.
- R6: ramp_sel_o equals copy_en_o. x_defl_o/y_defl_o carry x_ramp_i/y_ramp_i while copy_en_o is high, and x_norm_i/y_norm_i otherwise.
- R7: While copy_en_o is high, a falling edge on inter_ni makes z_pulse_o go high on the third rising edge after the fall is first sampled. It then stays high for exactly Z_LEN cycles. hc_int_sel_o is high for the whole pulse.
- R8: A falling edge on inter_ni while copy_en_o is low produces no Z pulse. z_pulse_o is never high while copy_en_o is low.
- R9: A falling edge on inter_ni during an active Z pulse neither extends nor retriggers it, and it leaves no pulse behind.
- R10: A low level on read_ni or wait_ni while no request is pending leaves copy_en_o low.
- R11: After reset, make_copy_no is high and copy_en_o, busy_o and z_pulse_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| kbd_copy_i | input | 1 | Keyboard copy request |
| cmd_copy_i | input | 1 | Software command copy request |
| btn_copy_i | input | 1 | Copier button copy request |
| read_ni | input | 1 | Copier reply: copying this display, active low, asynchronous |
| wait_ni | input | 1 | Copier reply: busy with another display, active low, asynchronous |
| inter_ni | input | 1 | Interrogation strobe, active low, asynchronous |
| erase_req_i | input | 1 | Erase request from display control |
| x_norm_i | input | COORD_W | Normal X deflection code |
| y_norm_i | input | COORD_W | Normal Y deflection code |
| x_ramp_i | input | COORD_W | Copier X ramp code |
| y_ramp_i | input | COORD_W | Copier Y ramp code |
| make_copy_no | output | 1 | Make-copy request to the copier, active low |
| copy_en_o | output | 1 | Copy enable level |
| busy_o | output | 1 | Display busy to the host |
| erase_o | output | 1 | Gated erase command |
| ramp_sel_o | output | 1 | Deflection source select, 1 = ramp |
| x_defl_o | output | COORD_W | Selected X deflection |
| y_defl_o | output | COORD_W | Selected Y deflection |
| z_pulse_o | output | 1 | Z-axis interrogation pulse |
| hc_int_sel_o | output | 1 | Hard-copy intensity select |

## Verification
Suppose the request state machine is in the wrong state. That shows within one cycle as make_copy_no and copy_en_o being low together or both inactive at the wrong time, or as the timeout length being off by a cycle. A wrong synchroniser depth moves the copy_en_o rise and fall by whole cycles. The bench therefore samples both edges at exact cycle counts. A stale Z counter shows as a pulse longer or shorter than Z_LEN, or as a ghost pulse after a retriggering strobe, so the bench counts pulse width and watches the quiet cycles that follow. The deflection and erase gating are compared with randomised coordinates in both copy-enable states.

// File: rtl/hc_pkg.sv
package hc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_COPY = 2'd2
  } hc_state_e;
endpackage

// File: rtl/hc_sync.sv
module hc_sync #(
  parameter int          WIDTH   = 1,
  parameter logic [63:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/hc_req_fsm.sv
module hc_req_fsm
  import hc_pkg::*;
#(
  parameter int REQ_TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic reply_i,
  output logic make_copy_no,
  output logic copy_en_o
);
  localparam int CNT_W = $clog2(REQ_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REQ_TIMEOUT - 1);

  hc_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (trig_i) state_d = ST_REQ;
      ST_REQ: begin
        if (reply_i)            state_d = ST_COPY;
        else if (cnt_q == LAST) state_d = ST_IDLE;
      end
      ST_COPY: if (!reply_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= (state_q == ST_REQ && state_d == ST_REQ) ? cnt_q + 1'b1 : '0;
    end
  end

  assign make_copy_no = (state_q != ST_REQ);
  assign copy_en_o    = (state_q == ST_COPY);

  // copy enable only follows a pending request
  p_en_after_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(copy_en_o) |-> $past(!make_copy_no));
  p_timeout_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ) |-> (cnt_q <= LAST));
  p_en_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_en_o && reply_i) |=> copy_en_o);
  p_idle_reply_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> !copy_en_o);
endmodule

// File: rtl/hc_zgen.sv
module hc_zgen #(
  parameter int Z_LEN = 26
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic copy_en_i,
  input  logic inter_n_s_i,
  output logic z_pulse_o
);
  localparam int ZW = $clog2(Z_LEN + 1);
  localparam logic [ZW-1:0] LOAD = ZW'(Z_LEN);

  logic          inter_prev_q;
  logic [ZW-1:0] z_cnt_q;
  logic          strobe;

  assign strobe = inter_prev_q && !inter_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inter_prev_q <= 1'b1;
      z_cnt_q      <= '0;
    end else begin
      inter_prev_q <= inter_n_s_i;
      if (!copy_en_i)                 z_cnt_q <= '0;
      else if (z_cnt_q != '0)         z_cnt_q <= z_cnt_q - 1'b1;
      else if (strobe)                z_cnt_q <= LOAD;
    end
  end

  // pulse is cut the moment copy enable drops
  assign z_pulse_o = (z_cnt_q != '0) && copy_en_i;

  p_z_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(z_cnt_q != '0) |-> (z_cnt_q == LOAD));
  p_z_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(z_pulse_o) |-> $past(copy_en_i));
  p_no_retrigger_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (z_cnt_q != '0 && copy_en_i) |=> (z_cnt_q == $past(z_cnt_q) - ZW'(1)));
endmodule

// File: rtl/hc_handshake.sv
module hc_handshake #(
  parameter int COORD_W     = 10,
  parameter int REQ_TIMEOUT = 16,
  parameter int Z_LEN       = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               kbd_copy_i,
  input  logic               cmd_copy_i,
  input  logic               btn_copy_i,
  input  logic               read_ni,
  input  logic               wait_ni,
  input  logic               inter_ni,
  input  logic               erase_req_i,
  input  logic [COORD_W-1:0] x_norm_i,
  input  logic [COORD_W-1:0] y_norm_i,
  input  logic [COORD_W-1:0] x_ramp_i,
  input  logic [COORD_W-1:0] y_ramp_i,
  output logic               make_copy_no,
  output logic               copy_en_o,
  output logic               busy_o,
  output logic               erase_o,
  output logic               ramp_sel_o,
  output logic [COORD_W-1:0] x_defl_o,
  output logic [COORD_W-1:0] y_defl_o,
  output logic               z_pulse_o,
  output logic               hc_int_sel_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] async_raw, async_s;
  logic             reply_s, any_trig, copy_en;

  assign async_raw = {inter_ni, wait_ni, read_ni};

  hc_sync #(.WIDTH(NSYNC), .RST_VAL('1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_raw),
    .q_o   (async_s)
  );

  assign reply_s  = !async_s[0] || !async_s[1];
  assign any_trig = kbd_copy_i || cmd_copy_i || btn_copy_i;

  hc_req_fsm #(.REQ_TIMEOUT(REQ_TIMEOUT)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (any_trig),
    .reply_i     (reply_s),
    .make_copy_no(make_copy_no),
    .copy_en_o   (copy_en)
  );

  hc_zgen #(.Z_LEN(Z_LEN)) u_zgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .copy_en_i  (copy_en),
    .inter_n_s_i(async_s[2]),
    .z_pulse_o  (z_pulse_o)
  );

  assign copy_en_o    = copy_en;
  assign busy_o       = copy_en;
  assign ramp_sel_o   = copy_en;
  assign hc_int_sel_o = copy_en;
  assign erase_o      = erase_req_i && !copy_en;
  assign x_defl_o     = copy_en ? x_ramp_i : x_norm_i;
  assign y_defl_o     = copy_en ? y_ramp_i : y_norm_i;

  p_erase_blocked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_en_o |-> !erase_o);
  p_z_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_pulse_o |-> (copy_en_o && hc_int_sel_o));
  p_req_en_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(make_copy_no) |-> !copy_en_o);
endmodule

// File: tb/hc_handshake_bench.sv
`timescale 1ns/1ps
module hc_handshake_bench;
  localparam int W  = 10;
  localparam int TO = 16;
  localparam int ZL = 26;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic kbd, cmd, btn, rd_n, wt_n, in_n, er_req;
  logic [W-1:0] xn, yn, xr, yr;
  logic mk_n, cen, busy, er, rsel, z, isel;
  logic [W-1:0] xd, yd;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hc_handshake #(.COORD_W(W), .REQ_TIMEOUT(TO), .Z_LEN(ZL)) u_hc_handshake (
    .clk_i(clk), .rst_ni(rst_ni),
    .kbd_copy_i(kbd), .cmd_copy_i(cmd), .btn_copy_i(btn),
    .read_ni(rd_n), .wait_ni(wt_n), .inter_ni(in_n), .erase_req_i(er_req),
    .x_norm_i(xn), .y_norm_i(yn), .x_ramp_i(xr), .y_ramp_i(yr),
    .make_copy_no(mk_n), .copy_en_o(cen), .busy_o(busy), .erase_o(er),
    .ramp_sel_o(rsel), .x_defl_o(xd), .y_defl_o(yd),
    .z_pulse_o(z), .hc_int_sel_o(isel)
  );

  function automatic logic [W-1:0] exp_defl(logic en, logic [W-1:0] nrm, logic [W-1:0] rmp);
    return en ? rmp : nrm;
  endfunction

  function automatic logic exp_erase(logic en, logic req);
    return req && !en;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_trig(int k);
    kbd = (k == 0); cmd = (k == 1); btn = (k == 2);
    tick();
    kbd = 0; cmd = 0; btn = 0;
  endtask

  task automatic rand_gating(logic en_exp, int n);
    for (int i = 0; i < n; i++) begin
      xn = W'($urandom); yn = W'($urandom); xr = W'($urandom); yr = W'($urandom);
      er_req = 1'($urandom);
      #1;
      chk("R6 x", xd, exp_defl(en_exp, xn, xr));
      chk("R6 y", yd, exp_defl(en_exp, yn, yr));
      chk("R6 sel", rsel, en_exp);
      chk("R5 erase", er, exp_erase(en_exp, er_req));
      chk("R5 busy", busy, en_exp);
      tick();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5EED1));
    kbd = 0; cmd = 0; btn = 0; rd_n = 1; wt_n = 1; in_n = 1; er_req = 0;
    xn = '0; yn = '0; xr = '0; yr = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();

    // R11 reset state
    chk("R11 make", mk_n, 1); chk("R11 en", cen, 0);
    chk("R11 busy", busy, 0); chk("R11 z", z, 0);

    // R10 reply with nothing pending
    rd_n = 0;
    repeat (5) tick();
    chk("R10 en", cen, 0); chk("R10 make", mk_n, 1);
    rd_n = 1;
    repeat (4) tick();

    // R8 strobe while disabled
    in_n = 0; tick(); tick(); in_n = 1;
    n = 0;
    for (int i = 0; i < 8; i++) begin if (z) n++; tick(); end
    chk("R8 no pulse idle", n, 0);

    // R1 / R2 timeout
    pulse_trig(0);
    chk("R1 kbd make", mk_n, 0);
    n = 0;
    while (!mk_n && n < 100) begin n++; tick(); end
    chk("R2 timeout len", n, TO);
    chk("R2 en after timeout", cen, 0);
    rand_gating(1'b0, 30);

    // R1 via command, wait reply, R3 timing
    pulse_trig(1);
    chk("R1 cmd make", mk_n, 0);
    wt_n = 0;
    tick(); tick();
    chk("R3 en early", cen, 0);
    tick();
    chk("R3 en", cen, 1);
    chk("R3 make release", mk_n, 1);
    rand_gating(1'b1, 30);

    // R7 / R9 interrogation pulse
    in_n = 0; tick(); tick();
    chk("R7 z early", z, 0);
    in_n = 1; tick();
    chk("R7 z start", z, 1);
    chk("R7 intensity", isel, 1);
    n = 0;
    while (z && n < 200) begin
      n++;
      if (n == 5) in_n = 0;
      if (n == 7) in_n = 1;
      tick();
    end
    chk("R9 z len", n, ZL);
    n = 0;
    for (int i = 0; i < 10; i++) begin if (z) n++; tick(); end
    chk("R9 no ghost", n, 0);

    // R4 hold while either reply low, then release
    rd_n = 0; tick(); wt_n = 1;
    repeat (4) tick();
    chk("R4 hold", cen, 1);
    rd_n = 1; tick(); tick();
    chk("R4 still", cen, 1);
    tick();
    chk("R4 fall", cen, 0);
    chk("R4 make", mk_n, 1);
    repeat (3) tick();

    // random rounds: trigger source and reply line
    for (int r = 0; r < 6; r++) begin
      int k = int'($urandom_range(0, 2));
      bit use_rd = 1'($urandom);
      pulse_trig(k);
      chk("R1 rnd make", mk_n, 0);
      if (use_rd) rd_n = 0; else wt_n = 0;
      tick(); tick();
      chk("R3 rnd early", cen, 0);
      tick();
      chk("R3 rnd en", cen, 1);
      rand_gating(1'b1, 4);
      rd_n = 1; wt_n = 1;
      tick(); tick(); tick();
      chk("R4 rnd fall", cen, 0);
      repeat (2) tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule